// File: doc/BRIEF.md
# Framed Serial Link to TDM Audio Receiver

This block sits in a speaker cabinet at the far end of a one-way serial audio link. The link has three wires: a bit clock, a data line and an active-low select line. The received 12.288 MHz bit clock is 256 times 48 kHz. It is the only clock in the block, and the same clock drives the DAC as its master clock, so the receiver and the DAC can never drift apart.

Every slot on the link is 32 bits long. A slot holds one 24-bit sample, a line-coding flag and a channel tag. When the flag is set, the sample was sent inverted on every other bit to keep the line DC balanced, and the receiver undoes that inversion. The receiver checks that the channel tags arrive in order and stores each group of eight samples in a two-bank frame store. Each completed frame is then sent out on an 8-slot TDM port, one frame period later.

Top module: `linkTdmRx`

## Requirements
- R1: While reset is held, `tdmData` and `syncErr` are 0 and `tdmFsync` is 1. After reset the TDM timing runs on its own, with a one-clock `tdmFsync` pulse every 256 clocks.
- R2: A slot starts on the clock in which `selN` is sampled low after being high. That bit is slot bit 31, and the remaining bits follow MSB first, one per clock, ending with bit 0. Bits 31..8 hold the sample, bit 3 is the coding flag and bits 2..0 are the channel tag. `selN` must be high for at least one clock between slots.
- R3: When the coding flag (bit 3) is 1, the received sample is XORed with 24'h555555 to recover the original sample. When the flag is 0, the sample is used as received.
- R4: A frame is eight slots tagged 0 to 7 in order. The clock after the last bit of an accepted slot tagged 7, `tdmFsync` is 1 and the TDM output starts sending that frame.
- R5: A TDM frame is 256 clocks long and holds eight 32-bit slots. TDM slot k carries channel k as 24 sample bits MSB first, followed by 8 zero bits.
- R6: Until the first complete, in-order frame has been received, `tdmData` stays 0.
- R7: If a tag arrives out of order, `syncErr` goes to 1 and stays there until reset. The partial frame never reaches the output, and the receiver accepts slots again starting from the next slot tagged 0. A slot tagged 0 always starts a new frame.
- R8: A falling edge of `selN` in the middle of a slot restarts the bit count. The cut-short slot is dropped without raising `syncErr`.
- R9: When no new frame arrives, the TDM output keeps repeating the last frame it received, with `tdmFsync` every 256 clocks.
- R10: Slot bits 7..4 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Received link bit clock, also the DAC master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serData | input | 1 | Link serial data, MSB first |
| selN | input | 1 | Link select, active low; its falling edge marks bit 31 of a slot |
| tdmData | output | 1 | TDM serial data to the DAC |
| tdmFsync | output | 1 | TDM frame sync, high for one clock at the start of slot 0 |
| syncErr | output | 1 | Sticky flag for an out-of-order channel tag |

## Verification
A sweep of frames uses walking-one and arithmetic samples, and each frame uses a different mix of coding flags and pad bits. A wrong bit order, a missing or extra XOR, or a pad bit leaking into a sample each shows up in a specific output slot. Zero and all-ones samples sent with the flag set show whether the mask is applied to all 24 bits. Separate sequences cover three cases that look alike at the output but must be told apart: a slot cut short mid-way, which must be dropped silently; a tag skipped in the middle of a frame, which must raise the error and hold the old frame; and a fresh tag 0 arriving mid-frame, which must start a new frame. A long idle period confirms that the frame-sync period stays steady and the last frame keeps repeating.

// File: rtl/linkTdmRxPkg.sv
package linkTdmRxPkg;
  localparam int SLOT_W   = 32;
  localparam int SAMPLE_W = 24;
  localparam int CHANNELS = 8;
  localparam int FLAG_BIT = 3;
  localparam int CH_W     = $clog2(CHANNELS);
  localparam int CNT_W    = $clog2(SLOT_W);
  localparam int FRAME_W  = $clog2(SLOT_W * CHANNELS);
  localparam logic [SAMPLE_W-1:0] LINE_MASK = {(SAMPLE_W/2){2'b01}};

  typedef struct packed {
    logic               wrEn;
    logic               wrBank;
    logic [CH_W-1:0]    wrCh;
    logic               rdBank;
    logic               live;
    logic [FRAME_W-1:0] tdmCnt;
  } rxStrb_t;
endpackage

// File: rtl/linkTdmRxCtrl.sv
module linkTdmRxCtrl
  import linkTdmRxPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            selN,
  input  logic [CH_W-1:0] slotCh,
  output rxStrb_t         strb,
  output logic            slotDone,
  output logic            frameDone,
  output logic            syncErr
);
  logic             selPrev;
  logic             aligned;
  logic [CNT_W-1:0] bitCnt;
  logic             fall;
  logic             hunt;
  logic [CH_W-1:0]  expCh;
  logic             accept;
  logic             errNow;
  logic             wrBank;
  logic             rdBank;
  logic             live;
  logic [FRAME_W-1:0] tdmCnt;

  assign fall     = selPrev && !selN;
  assign slotDone = aligned && !fall && (bitCnt == CNT_W'(SLOT_W - 1));

  // slot alignment: a select fall always restarts the count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev <= 1'b1;
      aligned <= 1'b0;
      bitCnt  <= '0;
    end else begin
      selPrev <= selN;
      if (fall) begin
        aligned <= 1'b1;
        bitCnt  <= CNT_W'(1);
      end else if (aligned) begin
        if (bitCnt == CNT_W'(SLOT_W - 1)) begin
          aligned <= 1'b0;
          bitCnt  <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // channel sequencing
  assign accept    = slotDone && ((slotCh == '0) || (!hunt && slotCh == expCh));
  assign errNow    = slotDone && !hunt && (slotCh != expCh);
  assign frameDone = accept && (slotCh == CH_W'(CHANNELS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hunt    <= 1'b1;
      expCh   <= '0;
      syncErr <= 1'b0;
    end else begin
      if (accept) begin
        hunt  <= 1'b0;
        expCh <= slotCh + 1'b1;
      end else if (errNow) begin
        hunt  <= 1'b1;
        expCh <= '0;
      end
      if (errNow) syncErr <= 1'b1;
    end
  end

  // bank swap and TDM frame timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBank <= 1'b0;
      rdBank <= 1'b1;
      live   <= 1'b0;
      tdmCnt <= '0;
    end else begin
      if (frameDone) begin
        wrBank <= !wrBank;
        rdBank <= wrBank;
        live   <= 1'b1;
        tdmCnt <= '0;
      end else begin
        tdmCnt <= tdmCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.wrEn   = accept;
    strb.wrBank = wrBank;
    strb.wrCh   = slotCh;
    strb.rdBank = rdBank;
    strb.live   = live;
    strb.tdmCnt = tdmCnt;
  end
endmodule

// File: rtl/linkTdmRxData.sv
module linkTdmRxData
  import linkTdmRxPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            serData,
  input  rxStrb_t         strb,
  output logic [CH_W-1:0] slotCh,
  output logic            tdmData,
  output logic            tdmFsync
);
  localparam int BANKS = 2;

  logic [SLOT_W-2:0]   shiftReg;
  logic [SLOT_W-1:0]   word;
  logic [SAMPLE_W-1:0] rawSample;
  logic [SAMPLE_W-1:0] lineMask;
  logic [SAMPLE_W-1:0] sample;
  logic [SAMPLE_W-1:0] store [BANKS][CHANNELS];
  logic [SAMPLE_W-1:0] curSample;
  logic [SAMPLE_W-1:0] shifted;
  logic [CH_W-1:0]     slotIdx;
  logic [CNT_W-1:0]    bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else       shiftReg <= {shiftReg[SLOT_W-3:0], serData};
  end

  assign word      = {shiftReg, serData};
  assign slotCh    = word[CH_W-1:0];
  assign rawSample = word[SLOT_W-1 -: SAMPLE_W];

  for (genvar i = 0; i < SAMPLE_W; i++) begin : g_mask
    assign lineMask[i] = (i % 2 == 0);
  end

  assign sample = word[FLAG_BIT] ? (rawSample ^ lineMask) : rawSample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < BANKS; b++)
        for (int c = 0; c < CHANNELS; c++)
          store[b][c] <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++)
        for (int c = 0; c < CHANNELS; c++)
          if (strb.wrEn && strb.wrBank == 1'(b) && strb.wrCh == CH_W'(c))
            store[b][c] <= sample;
    end
  end

  assign slotIdx   = strb.tdmCnt[FRAME_W-1:CNT_W];
  assign bitIdx    = strb.tdmCnt[CNT_W-1:0];
  assign curSample = store[strb.rdBank][slotIdx];
  assign shifted   = curSample << bitIdx;
  assign tdmData   = strb.live && (bitIdx < CNT_W'(SAMPLE_W)) && shifted[SAMPLE_W-1];
  assign tdmFsync  = (strb.tdmCnt == '0);
endmodule

// File: rtl/linkTdmRx.sv
module linkTdmRx
  import linkTdmRxPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic serData,
  input  logic selN,
  output logic tdmData,
  output logic tdmFsync,
  output logic syncErr
);
  rxStrb_t         strb;
  logic [CH_W-1:0] slotCh;
  logic            slotDone;
  logic            frameDone;

  linkTdmRxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .slotCh(slotCh),
    .strb(strb), .slotDone(slotDone), .frameDone(frameDone), .syncErr(syncErr)
  );

  linkTdmRxData u_data (
    .clk(clk), .rstN(rstN), .serData(serData), .strb(strb),
    .slotCh(slotCh), .tdmData(tdmData), .tdmFsync(tdmFsync)
  );
endmodule

// File: rtl/linkTdmRxChk.sv
module linkTdmRxChk
  import linkTdmRxPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             slotDone,
  input logic             frameDone,
  input logic             live,
  input logic [CNT_W-1:0] bitPos,
  input logic             tdmData,
  input logic             tdmFsync,
  input logic             syncErr
);
  AST_FRAME_STARTS_TDM: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> tdmFsync); // R4

  AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (bitPos >= CNT_W'(SAMPLE_W)) |-> !tdmData); // R5

  AST_MUTE_UNTIL_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    !live |-> !tdmData); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> syncErr); // R7

  AST_ERR_ON_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncErr) |-> $past(slotDone)); // R7
endmodule

bind linkTdmRx linkTdmRxChk u_chk (
  .clk(clk), .rstN(rstN), .slotDone(slotDone), .frameDone(frameDone),
  .live(strb.live), .bitPos(strb.tdmCnt[linkTdmRxPkg::CNT_W-1:0]),
  .tdmData(tdmData), .tdmFsync(tdmFsync), .syncErr(syncErr)
);

// File: tb/linkTdmRx_bench.sv
`timescale 1ns/1ps
module linkTdmRx_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData = 1'b0;
  logic selN = 1'b1;
  logic tdmData, tdmFsync, syncErr;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int lastBitCyc = 0;
  int lastFs = -1;
  int prevFs = -1;
  int monIdx = 256;
  int frames = 0;
  bit done = 1'b0;
  logic [31:0] curW [8];
  logic [31:0] lastFrame [8];
  logic [23:0] sv [8];

  always #2.5 clk = ~clk;

  linkTdmRx u_linkTdmRx (
    .clk(clk), .rstN(rstN), .serData(serData), .selN(selN),
    .tdmData(tdmData), .tdmFsync(tdmFsync), .syncErr(syncErr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // TDM output monitor
  always @(negedge clk) begin
    if (tdmFsync) begin
      prevFs = lastFs;
      lastFs = cyc;
      monIdx = 0;
    end
    if (monIdx < 256) begin
      curW[monIdx / 32][31 - (monIdx % 32)] = tdmData;
      monIdx++;
      if (monIdx == 256) begin
        for (int k = 0; k < 8; k++) lastFrame[k] = curW[k];
        frames++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sendSlot(input logic [23:0] s, input bit flag, input int ch,
                          input logic [3:0] junk);
    logic [31:0] w;
    w = {(flag ? (s ^ 24'h555555) : s), junk, flag, 3'(ch)};
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      serData = w[i];
      selN = (i == 0);
    end
    @(posedge clk);
    #1 lastBitCyc = cyc;
  endtask

  task automatic sendPartial(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      serData = i[0];
      selN = 1'b0;
    end
    @(negedge clk);
    selN = 1'b1;
    serData = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      selN = 1'b1;
      serData = 1'b0;
    end
  endtask

  task automatic sendFrame(input int flagMode, input int junkSeed);
    for (int c = 0; c < 8; c++)
      sendSlot(sv[c], (flagMode == 2) ? 1'b1 : (flagMode == 0 ? 1'b0 : bit'((c + junkSeed) % 2)),
               c, 4'((junkSeed * 3 + c * 7) % 16));
  endtask

  task automatic checkFrame(input string req);
    for (int c = 0; c < 8; c++)
      check(lastFrame[c] == {sv[c], 8'h00}, req, $sformatf("tdm slot %0d", c),
            lastFrame[c], {sv[c], 8'h00});
  endtask

  initial begin
    repeat (1) begin
      int fsA;
      // R1 reset state
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(tdmData == 1'b0, "R1", "tdmData in reset", 32'(tdmData), 0);
      check(syncErr == 1'b0, "R1", "syncErr in reset", 32'(syncErr), 0);
      check(tdmFsync == 1'b1, "R1", "tdmFsync in reset", 32'(tdmFsync), 1);
      rstN = 1'b1;
      idle(600);
      check(lastFs - prevFs == 256, "R1", "free-running fsync period", 32'(lastFs - prevFs), 256);
      check(syncErr == 1'b0, "R1", "syncErr after reset", 32'(syncErr), 0);
      // R6 mute before any frame
      check(frames >= 1, "R6", "frames observed", 32'(frames), 1);
      for (int c = 0; c < 8; c++)
        check(lastFrame[c] == 32'h0, "R6", "muted slot", lastFrame[c], 0);

      // R2 R3 R4 R5 R10 sweep
      for (int k = 0; k < 16; k++) begin
        for (int c = 0; c < 8; c++)
          sv[c] = (24'h1 << ((k + c * 5) % 24)) ^ 24'(k * 24'h0A3C1 + c * 24'h11111);
        sendFrame(k % 3, k);
        idle(2);
        check(lastFs == lastBitCyc, "R4", "fsync right after tag 7", 32'(lastFs), 32'(lastBitCyc));
        idle(270);
        checkFrame((k % 3 == 0) ? "R2" : "R3");
      end

      // R3 mask covers all bits
      for (int c = 0; c < 8; c++) sv[c] = c[0] ? 24'hFFFFFF : 24'h000000;
      sendFrame(2, 5);
      idle(272);
      checkFrame("R3");

      // R10 pad bits: same samples, different junk, flag off
      for (int c = 0; c < 8; c++) sv[c] = 24'hC3A500 + 24'(c);
      sendFrame(0, 11);
      idle(272);
      checkFrame("R10");

      // R9 repeat last frame while idle
      idle(700);
      check(lastFs - prevFs == 256, "R9", "idle fsync period", 32'(lastFs - prevFs), 256);
      checkFrame("R9");

      // R8 select falls mid-slot
      for (int c = 0; c < 8; c++) sv[c] = 24'h3F0000 ^ 24'(c * 24'h050301);
      sendSlot(sv[0], 1'b0, 0, 4'h0);
      sendPartial(12);
      for (int c = 1; c < 8; c++) sendSlot(sv[c], 1'b1, c, 4'h9);
      idle(2);
      check(lastFs == lastBitCyc, "R8", "frame after cut slot", 32'(lastFs), 32'(lastBitCyc));
      idle(270);
      checkFrame("R8");
      check(syncErr == 1'b0, "R8", "no error on cut slot", 32'(syncErr), 0);

      // R7 skipped tag
      for (int c = 0; c < 8; c++) sv[c] = 24'h00F00F + 24'(c * 24'h101);
      sendFrame(1, 2);
      idle(2);
      fsA = lastFs;
      sendSlot(24'hDEAD00, 1'b0, 0, 4'h0);
      sendSlot(24'hDEAD01, 1'b0, 1, 4'h0);
      sendSlot(24'hDEAD02, 1'b0, 2, 4'h0);
      sendSlot(24'hDEAD05, 1'b0, 5, 4'h0);
      idle(3);
      check(syncErr == 1'b1, "R7", "syncErr on skipped tag", 32'(syncErr), 1);
      sendSlot(24'hDEAD06, 1'b0, 6, 4'h0);
      sendSlot(24'hDEAD07, 1'b0, 7, 4'h0);
      idle(2);
      check((lastFs == lastBitCyc) == ((lastBitCyc - fsA) % 256 == 0), "R7",
            "no realign while hunting", 32'(lastFs), 32'(lastBitCyc));
      idle(300);
      checkFrame("R7");
      // resync on tag 0, error stays
      for (int c = 0; c < 8; c++) sv[c] = 24'h7E0000 | 24'(c * 24'h0123);
      sendFrame(0, 4);
      idle(272);
      checkFrame("R7");
      check(syncErr == 1'b1, "R7", "syncErr sticky", 32'(syncErr), 1);
      // tag 0 mid-frame starts a new frame
      sendSlot(24'h111111, 1'b0, 0, 4'h0);
      sendSlot(24'h222222, 1'b0, 1, 4'h0);
      for (int c = 0; c < 8; c++) sv[c] = 24'hA00000 + 24'(c * 24'h0F0F);
      sendFrame(1, 9);
      idle(2);
      check(lastFs == lastBitCyc, "R7", "restart on tag 0", 32'(lastFs), 32'(lastBitCyc));
      idle(270);
      checkFrame("R7");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule